// File: doc/BRIEF.md
# Boot-Overlay Address Decoder

This block decodes every access of a 24-bit address, 16-bit data processor bus. The space is cut into 64 windows of 256 KB, picked by the top six address bits. The decoder raises one select per access: chip RAM, boot ROM, or one or both of two byte-wide peripheral chips. It also reports whether the window may be read and whether it may be written.

After reset a boot overlay places the ROM over the bottom 512 KB, so the processor fetches its first vectors from ROM. Software turns the overlay off by driving bit 0 of the first peripheral's first port low, configured as an output. From then on the same window is read/write RAM.

The two peripherals share the data bus. The first uses the upper byte lane and the second uses the lower one. Each is chosen by its own active-low address bit. The decoder steers write bytes to each chip. On reads it builds the returned word from the two peripheral read bytes, and a lane that no chip drives reads back as all ones.

Top module: `boot_overlay_decoder`

## Requirements
- R1: The window index is `addr_i[23:18]`. Window 63 (0xFC0000 to 0xFFFFFF) always selects ROM (`rom_sel_o`), with `perm_rd_o`=1 and `perm_wr_o`=0.
- R2: While `overlay_o` is 1, windows 0 and 1 (0x000000 to 0x07FFFF) select ROM, with read permitted and write not permitted.
- R3: While `overlay_o` is 0, windows 0 and 1 select RAM (`ram_sel_o`), with read and write permitted. `mem_we_o` is high exactly for write requests to RAM.
- R4: `overlay_o` is 1 during and after reset. On each clock edge it loads the effective level of control bit 0, which is `port_out_i[0] | ~port_dir_i[0]`, where a direction bit of 1 means output. A new level takes effect on the access in the next cycle.
- R5: A peripheral access is any request with `addr_i[23:21]`=3'b101 that falls in a window with no memory. No other address raises a peripheral select.
- R6: Peripheral A (`pa_sel_o`) is chosen when `addr_i[12]`=0, and peripheral B (`pb_sel_o`) when `addr_i[13]`=0. Both may be chosen together. The register number `reg_o` is `addr_i[11:8]`.
- R7: On a peripheral read, `rdata_o` starts at 0xFFFF. Peripheral A's byte replaces bits 15:8 and peripheral B's byte replaces bits 7:0, each only when that chip is selected.
- R8: On a peripheral write, `pa_we_o`/`pb_we_o` pulse for the selected chips. `pa_wdata_o` carries `wdata_i[15:8]` and `pb_wdata_o` carries `wdata_i[7:0]`.
- R9: A write to a ROM window raises no write strobe. `bus_err_wr_o` is high for exactly the cycle after each such request.
- R10: Any request outside the ROM, RAM and peripheral cases (for example 0x200000) raises no select and grants no permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 24 | Byte address |
| wdata_i | input | 16 | Write data |
| port_out_i | input | 8 | Peripheral A port output latch |
| port_dir_i | input | 8 | Peripheral A port direction (1 = output) |
| pa_rdata_i | input | 8 | Peripheral A read byte |
| pb_rdata_i | input | 8 | Peripheral B read byte |
| ram_sel_o | output | 1 | RAM selected |
| rom_sel_o | output | 1 | ROM selected |
| perm_rd_o | output | 1 | Window readable |
| perm_wr_o | output | 1 | Window writable |
| mem_we_o | output | 1 | RAM write strobe |
| pa_sel_o | output | 1 | Peripheral A selected |
| pb_sel_o | output | 1 | Peripheral B selected |
| pa_we_o | output | 1 | Peripheral A write strobe |
| pb_we_o | output | 1 | Peripheral B write strobe |
| reg_o | output | 4 | Peripheral register number |
| pa_wdata_o | output | 8 | Byte to peripheral A |
| pb_wdata_o | output | 8 | Byte to peripheral B |
| rdata_o | output | 16 | Assembled peripheral read word |
| bus_err_wr_o | output | 1 | Write-to-ROM flag, one cycle late |
| overlay_o | output | 1 | Current overlay state |

## Verification
The bench toggles the overlay in both directions. A design that updated it in the same cycle, or ignored the direction bit, would return ROM where RAM is expected. It also writes to both ROM windows while the overlay is on: a decoder that let those writes through would raise `mem_we_o` or miss the error pulse. Peripheral accesses cover each chip alone, both at once and neither. Swapped lanes or an active-high select would show up as wrong bytes in `rdata_o` or the wrong write strobe. Unmapped addresses, both inside and outside the 0xA00000 block, catch decoders that select something where nothing should respond.

// File: rtl/bod_pkg.sv
package bod_pkg;
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_RAM  = 2'd1,
    WIN_ROM  = 2'd2
  } win_kind_e;
endpackage

// File: rtl/bod_overlay_reg.sv
module bod_overlay_reg #(
  parameter int PORT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] port_out_i,
  input  logic [PORT_W-1:0] port_dir_i,
  output logic              overlay_o
);
  // a pin set as input floats high
  logic eff_bit;
  assign eff_bit = port_out_i[0] | ~port_dir_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) overlay_o <= 1'b1;
    else         overlay_o <= eff_bit;
  end
endmodule

// File: rtl/bod_window_map.sv
module bod_window_map
  import bod_pkg::*;
#(
  parameter int WIN_BITS    = 6,
  parameter int OVL_WINS    = 2,
  parameter int ROM_TOP_WIN = 1
) (
  input  logic [WIN_BITS-1:0] idx_i,
  input  logic                overlay_i,
  output win_kind_e           kind_o
);
  localparam int NUM_WIN = 1 << WIN_BITS;

  win_kind_e tab [NUM_WIN];

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    if (g < OVL_WINS) begin : g_low
      assign tab[g] = overlay_i ? WIN_ROM : WIN_RAM;
    end else if (g >= NUM_WIN - ROM_TOP_WIN) begin : g_top
      assign tab[g] = WIN_ROM;
    end else begin : g_none
      assign tab[g] = WIN_NONE;
    end
  end

  assign kind_o = tab[idx_i];
endmodule

// File: rtl/bod_periph_lanes.sv
module bod_periph_lanes #(
  parameter int LANE_W = 8
) (
  input  logic                hit_i,
  input  logic                we_i,
  input  logic                a_n_i,
  input  logic                b_n_i,
  input  logic [2*LANE_W-1:0] wdata_i,
  input  logic [LANE_W-1:0]   a_rdata_i,
  input  logic [LANE_W-1:0]   b_rdata_i,
  output logic                a_sel_o,
  output logic                b_sel_o,
  output logic                a_we_o,
  output logic                b_we_o,
  output logic [LANE_W-1:0]   a_wdata_o,
  output logic [LANE_W-1:0]   b_wdata_o,
  output logic [2*LANE_W-1:0] rdata_o
);
  assign a_sel_o   = hit_i & ~a_n_i;
  assign b_sel_o   = hit_i & ~b_n_i;
  assign a_we_o    = a_sel_o & we_i;
  assign b_we_o    = b_sel_o & we_i;
  assign a_wdata_o = wdata_i[2*LANE_W-1:LANE_W];
  assign b_wdata_o = wdata_i[LANE_W-1:0];

  always_comb begin
    rdata_o = '1;
    if (a_sel_o && !we_i) rdata_o[2*LANE_W-1:LANE_W] = a_rdata_i;
    if (b_sel_o && !we_i) rdata_o[LANE_W-1:0]        = b_rdata_i;
  end
endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import bod_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int WIN_BITS    = 6,
  parameter int OVL_WINS    = 2,
  parameter int ROM_TOP_WIN = 1,
  parameter int PORT_W      = 8,
  parameter int REG_W       = 4,
  parameter int REG_LSB     = 8,
  parameter int SEL_A_BIT   = 12,
  parameter int SEL_B_BIT   = 13,
  parameter int PERIPH_TAG  = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [PORT_W-1:0]   port_out_i,
  input  logic [PORT_W-1:0]   port_dir_i,
  input  logic [DATA_W/2-1:0] pa_rdata_i,
  input  logic [DATA_W/2-1:0] pb_rdata_i,
  output logic                ram_sel_o,
  output logic                rom_sel_o,
  output logic                perm_rd_o,
  output logic                perm_wr_o,
  output logic                mem_we_o,
  output logic                pa_sel_o,
  output logic                pb_sel_o,
  output logic                pa_we_o,
  output logic                pb_we_o,
  output logic [REG_W-1:0]    reg_o,
  output logic [DATA_W/2-1:0] pa_wdata_o,
  output logic [DATA_W/2-1:0] pb_wdata_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                bus_err_wr_o,
  output logic                overlay_o
);
  localparam int LANE_W = DATA_W / 2;
  localparam int TAG_W  = 3;

  win_kind_e kind;
  logic      periph_hit;
  logic      err_d;

  bod_overlay_reg #(.PORT_W(PORT_W)) u_ovl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .port_out_i (port_out_i),
    .port_dir_i (port_dir_i),
    .overlay_o  (overlay_o)
  );

  bod_window_map #(
    .WIN_BITS    (WIN_BITS),
    .OVL_WINS    (OVL_WINS),
    .ROM_TOP_WIN (ROM_TOP_WIN)
  ) u_map (
    .idx_i     (addr_i[ADDR_W-1 -: WIN_BITS]),
    .overlay_i (overlay_o),
    .kind_o    (kind)
  );

  assign ram_sel_o = req_i && (kind == WIN_RAM);
  assign rom_sel_o = req_i && (kind == WIN_ROM);
  assign perm_rd_o = ram_sel_o | rom_sel_o;
  assign perm_wr_o = ram_sel_o;
  assign mem_we_o  = ram_sel_o & we_i;

  // peripherals live only where no memory answers
  assign periph_hit = req_i && (kind == WIN_NONE) &&
                      (addr_i[ADDR_W-1 -: TAG_W] == TAG_W'(PERIPH_TAG));
  assign reg_o = addr_i[REG_LSB +: REG_W];

  bod_periph_lanes #(.LANE_W(LANE_W)) u_lanes (
    .hit_i     (periph_hit),
    .we_i      (we_i),
    .a_n_i     (addr_i[SEL_A_BIT]),
    .b_n_i     (addr_i[SEL_B_BIT]),
    .wdata_i   (wdata_i),
    .a_rdata_i (pa_rdata_i),
    .b_rdata_i (pb_rdata_i),
    .a_sel_o   (pa_sel_o),
    .b_sel_o   (pb_sel_o),
    .a_we_o    (pa_we_o),
    .b_we_o    (pb_we_o),
    .a_wdata_o (pa_wdata_o),
    .b_wdata_o (pb_wdata_o),
    .rdata_o   (rdata_o)
  );

  assign err_d = rom_sel_o & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_err_wr_o <= 1'b0;
    else         bus_err_wr_o <= err_d;
  end
endmodule

// File: rtl/bod_checker.sv
module bod_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [23:0] addr_i,
  input logic        ram_sel_o,
  input logic        rom_sel_o,
  input logic        perm_wr_o,
  input logic        mem_we_o,
  input logic        pa_sel_o,
  input logic        pb_sel_o,
  input logic [15:0] rdata_o,
  input logic        bus_err_wr_o,
  input logic        overlay_o
);
  p_top_rom_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[23:18] == 6'h3f) |-> (rom_sel_o && !perm_wr_o));

  p_low_ovl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[23:19] == 5'd0) |-> (rom_sel_o == overlay_o));

  p_ram_we_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (ram_sel_o && perm_wr_o && !overlay_o));

  p_periph_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pa_sel_o || pb_sel_o) |-> (!ram_sel_o && !rom_sel_o && addr_i[23:21] == 3'b101));

  p_one_target_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ram_sel_o, rom_sel_o, pa_sel_o | pb_sel_o}));

  p_hi_lane_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pa_sel_o) |-> (rdata_o[15:8] == 8'hff));

  p_err_source_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && rom_sel_o) |=> bus_err_wr_o);

  p_err_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(req_i && we_i && rom_sel_o)) |=> !bus_err_wr_o);
endmodule

bind boot_overlay_decoder bod_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .ram_sel_o    (ram_sel_o),
  .rom_sel_o    (rom_sel_o),
  .perm_wr_o    (perm_wr_o),
  .mem_we_o     (mem_we_o),
  .pa_sel_o     (pa_sel_o),
  .pb_sel_o     (pb_sel_o),
  .rdata_o      (rdata_o),
  .bus_err_wr_o (bus_err_wr_o),
  .overlay_o    (overlay_o)
);

// File: tb/boot_overlay_decoder_tb_top.sv
module boot_overlay_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [7:0]  pout = '0, pdir = '0, ard = '0, brd = '0;

  logic        ram_sel, rom_sel, perm_rd, perm_wr, mem_we;
  logic        pa_sel, pb_sel, pa_we, pb_we, bus_err, ovl;
  logic [3:0]  reg_n;
  logic [7:0]  pa_wd, pb_wd;
  logic [15:0] rdata;

  always #4 clk = ~clk;

  boot_overlay_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .port_out_i(pout), .port_dir_i(pdir),
    .pa_rdata_i(ard), .pb_rdata_i(brd),
    .ram_sel_o(ram_sel), .rom_sel_o(rom_sel), .perm_rd_o(perm_rd),
    .perm_wr_o(perm_wr), .mem_we_o(mem_we), .pa_sel_o(pa_sel),
    .pb_sel_o(pb_sel), .pa_we_o(pa_we), .pb_we_o(pb_we), .reg_o(reg_n),
    .pa_wdata_o(pa_wd), .pb_wdata_o(pb_wd), .rdata_o(rdata),
    .bus_err_wr_o(bus_err), .overlay_o(ovl)
  );

  typedef struct {
    logic [46:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0, n_bad = 0;
  logic  ovl_m = 1'b1;
  logic  err_m = 1'b0;
  bit    done = 1'b0;

  function automatic logic [46:0] act_vec();
    return {ovl, bus_err, ram_sel, rom_sel, pa_sel, pb_sel, perm_rd, perm_wr,
            mem_we, pa_we, pb_we, reg_n, rdata, pa_wd, pb_wd};
  endfunction

  task automatic apply(input logic r, input logic w, input logic [23:0] a,
                       input logic [15:0] wd, input logic [7:0] ar,
                       input logic [7:0] br, input logic [7:0] po,
                       input logic [7:0] pd, input string tag);
    item_t it;
    logic [5:0] idx;
    logic low, top, mapped, e_ram, e_rom, e_pa, e_pb, per;
    logic [15:0] rd;
    @(negedge clk);
    req = r; we = w; addr = a; wdata = wd; ard = ar; brd = br;
    pout = po; pdir = pd;
    idx    = a[23:18];
    low    = (idx < 6'd2);
    top    = (idx == 6'd63);
    mapped = low | top;
    e_rom  = r & (top | (low & ovl_m));
    e_ram  = r & low & ~ovl_m;
    per    = r & ~mapped & (a[23:21] == 3'b101);
    e_pa   = per & ~a[12];
    e_pb   = per & ~a[13];
    rd     = 16'hffff;
    if (e_pa && !w) rd[15:8] = ar;
    if (e_pb && !w) rd[7:0]  = br;
    it.exp = {ovl_m, err_m, e_ram, e_rom, e_pa, e_pb, e_ram | e_rom, e_ram,
              e_ram & w, e_pa & w, e_pb & w, a[11:8], rd, wd[15:8], wd[7:0]};
    it.tag = tag;
    q.push_back(it);
    err_m = e_rom & w;
    ovl_m = po[0] | ~pd[0];
  endtask

  // monitor: compare combinational outputs late in the low phase
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (act_vec() !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act_vec(), it.exp);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20;
    n_chk++;
    if (ovl !== 1'b1 || bus_err !== 1'b0) begin
      n_bad++;
      $display("FAIL R4 reset: actual %b%b expected 10", ovl, bus_err);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2: overlay on after reset, low window is ROM
    apply(1, 0, 24'h000100, 16'h0, 8'h0, 8'h0, 8'h00, 8'h00, "R2 read low ovl");
    apply(1, 0, 24'h07fffe, 16'h0, 8'h0, 8'h0, 8'h00, 8'h00, "R2 read top of low");
    // R9: writes to ROM suppressed, flagged next cycle
    apply(1, 1, 24'h000010, 16'h1234, 8'h0, 8'h0, 8'h00, 8'h00, "R9 write low rom");
    apply(0, 0, 24'h000000, 16'h0, 8'h0, 8'h0, 8'h00, 8'h00, "R9 err pulse");
    apply(1, 1, 24'hfc0000, 16'h5678, 8'h0, 8'h0, 8'h00, 8'h00, "R1 write top rom");
    apply(1, 0, 24'hffffff, 16'h0, 8'h0, 8'h0, 8'h00, 8'h00, "R1 R9 read top rom");
    // R4: drive bit0 low as output; applies from next cycle
    apply(1, 0, 24'h000200, 16'h0, 8'h0, 8'h0, 8'h00, 8'h01, "R4 same cycle still rom");
    apply(1, 0, 24'h000200, 16'h0, 8'h0, 8'h0, 8'h00, 8'h01, "R3 R4 ram after clear");
    apply(1, 1, 24'h07fff0, 16'hbeef, 8'h0, 8'h0, 8'hfe, 8'hff, "R3 ram write");
    apply(1, 1, 24'hfc1000, 16'hbeef, 8'h0, 8'h0, 8'hfe, 8'hff, "R1 top rom with ovl off");
    // R10: unmapped
    apply(1, 0, 24'h200000, 16'h0, 8'h11, 8'h22, 8'hfe, 8'hff, "R10 unmapped read");
    apply(1, 1, 24'h9fe000, 16'h0, 8'h11, 8'h22, 8'hfe, 8'hff, "R5 R10 below periph block");
    // R5 R6 R7: peripheral reads
    apply(1, 0, 24'hbfe700, 16'h0, 8'ha5, 8'h5a, 8'hfe, 8'hff, "R6 R7 periph A read");
    apply(1, 0, 24'hbfd300, 16'h0, 8'ha5, 8'h5a, 8'hfe, 8'hff, "R6 R7 periph B read");
    apply(1, 0, 24'hbfcf00, 16'h0, 8'h3c, 8'hc3, 8'hfe, 8'hff, "R7 both read");
    apply(1, 0, 24'hbff000, 16'h0, 8'h3c, 8'hc3, 8'hfe, 8'hff, "R6 R7 neither");
    apply(1, 0, 24'ha00000, 16'h0, 8'h01, 8'h02, 8'hfe, 8'hff, "R5 base of block");
    // R8: peripheral writes
    apply(1, 1, 24'hbfe900, 16'hcafe, 8'h0, 8'h0, 8'hfe, 8'hff, "R8 write A");
    apply(1, 1, 24'hbfd100, 16'hcafe, 8'h0, 8'h0, 8'hfe, 8'hff, "R8 write B");
    apply(1, 1, 24'hbfc500, 16'hf00d, 8'h0, 8'h0, 8'hfe, 8'hff, "R8 write both");
    // R4: direction input makes bit0 read high, overlay returns
    apply(0, 0, 24'h000000, 16'h0, 8'h0, 8'h0, 8'h00, 8'h00, "R4 pin to input");
    apply(1, 1, 24'h000400, 16'h7777, 8'h0, 8'h0, 8'h00, 8'h00, "R2 R4 overlay back");
    apply(1, 0, 24'h040000, 16'h0, 8'h0, 8'h0, 8'h00, 8'h00, "R9 R2 window 1 rom");
    // R5: no request, no select
    apply(0, 1, 24'hbfc000, 16'h1111, 8'h0, 8'h0, 8'h00, 8'h00, "R5 idle");

    while (q.size() > 0) @(negedge clk);
    #5;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule